// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block collects interrupt requests from a configurable number of sources (35 by default) and presents one of them to the processor. Source `NMI_IDX` is non-maskable and always has level 7. Each other source has a 3-bit priority level that software writes through a small register port. A level of 0 turns that source off. Every source has a fixed vector number, equal to `VEC_BASE` plus its index.

Requests are caught in pending flags. Among the pending sources that are not turned off, the block keeps those whose level is at least the current mask value. The highest level among them wins, and a tie goes to the lower index. The winner's level and vector appear on registered outputs, marked by a valid strobe.

The processor changes the mask with an enable command, which loads a chosen level, or a disable command, which loads 7. When it acknowledges the presented interrupt, the pending flag of that source is cleared.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the mask is 7, every maskable level is 0, no flag is pending and `irq_valid_o` is low. In this state only the non-maskable source can be presented.
- R2: The vector presented for source i is `VEC_BASE + i`. With the defaults, `VEC_BASE` is 8'h20 and there are 35 sources.
- R3: A write with `wr_en_i` high sets the level of the source at `wr_addr_i` to `wr_data_i`. A value of 7 is stored as 6. A write to `NMI_IDX`, or to an address of `NUM_SRC` or above, changes nothing.
- R4: A maskable source with level 0 is never presented, even while its flag is pending.
- R5: The non-maskable source has level 7 at all times. When it is pending it is presented whatever the mask value, including 7.
- R6: Among the eligible pending sources, the one with the highest level is presented, and `irq_level_o` carries that level.
- R7: When several eligible pending sources share the highest level, the one with the lowest index is presented.
- R8: A pending source is eligible when its level is greater than or equal to the mask. `ei_i` loads the mask from `ei_lvl_i`. `di_i` loads 7, and it takes priority over `ei_i` in the same cycle.
- R9: A mask change takes effect at the clock edge where the command is sampled. The outputs after that edge already reflect the new mask.
- R10: A pulse on `req_i` sets that source's flag, and the flag stays set until the source is acknowledged. `ack_i` while `irq_valid_o` is high clears the flag of the presented source. A request on the same source in the same cycle keeps the flag set.
- R11: The outputs are registered. After each clock edge they show the winner computed from the pending flags, levels and mask as they stand after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | NUM_SRC | Request pulses, one bit per source |
| wr_en_i | input | 1 | Level write strobe |
| wr_addr_i | input | SRC_W | Source index of the level write |
| wr_data_i | input | 3 | Level value to write |
| ei_i | input | 1 | Enable command: load the mask from `ei_lvl_i` |
| ei_lvl_i | input | 3 | Mask value for the enable command |
| di_i | input | 1 | Disable command: load 7 into the mask |
| ack_i | input | 1 | Processor accepts the presented interrupt |
| irq_valid_o | output | 1 | An interrupt is being presented |
| irq_level_o | output | 3 | Level of the presented interrupt |
| irq_vec_o | output | VEC_W | Vector number of the presented interrupt |

## Verification
The assertions check four things on every cycle:
- a presented interrupt never has level 0 and is never below the mask;
- a level-7 interrupt always carries the non-maskable vector, and every vector lies in the valid range;
- after a disable command, nothing below level 7 is presented;
- a presented interrupt stays presented until an acknowledge, a mask command or a level write.

Only the bench's scenarios can show:
- the order of winners across levels and ties;
- the saturation of written levels and the ignored writes;
- a request that arrives in the same cycle as its own acknowledge;
- the exact cycle in which a mask change first shows at the outputs.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
   typedef logic [2:0] lvl_t;
   localparam lvl_t LVL_NMI      = 3'd7;
   localparam lvl_t LVL_MAX_MASK = 3'd6;
   localparam lvl_t LVL_OFF      = 3'd0;

   function automatic lvl_t clamp_lvl(input lvl_t v);
      return (v > LVL_MAX_MASK) ? LVL_MAX_MASK : v;
   endfunction
endpackage

// File: rtl/irq_pending.sv
module irq_pending #(
   parameter int NUM_SRC = 35,
   parameter int SRC_W   = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] req_i,
   input  logic               clr_en_i,
   input  logic [SRC_W-1:0]   clr_idx_i,
   output logic [NUM_SRC-1:0] pend_d
);
   logic [NUM_SRC-1:0] pend_q;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
      logic clr;
      assign clr       = clr_en_i && (clr_idx_i == SRC_W'(i));
      assign pend_d[i] = (pend_q[i] && !clr) || req_i[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= pend_d;
   end
endmodule

// File: rtl/irq_level_regs.sv
module irq_level_regs
   import prio_irq_pkg::*;
#(
   parameter int NUM_SRC = 35,
   parameter int SRC_W   = 6,
   parameter int NMI_IDX = 0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en_i,
   input  logic [SRC_W-1:0]       wr_addr_i,
   input  lvl_t                   wr_data_i,
   input  logic                   ei_i,
   input  lvl_t                   ei_lvl_i,
   input  logic                   di_i,
   output lvl_t [NUM_SRC-1:0]     lvl_d,
   output lvl_t                   mask_d,
   output lvl_t                   mask_q
);
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_lvl
      if (i == NMI_IDX) begin : g_fixed
         assign lvl_d[i] = LVL_NMI;
      end else begin : g_prog
         lvl_t lvl_q;
         assign lvl_d[i] = (wr_en_i && wr_addr_i == SRC_W'(i))
                           ? clamp_lvl(wr_data_i) : lvl_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lvl_q <= LVL_OFF;
            else        lvl_q <= lvl_d[i];
         end
      end
   end

   always_comb begin
      mask_d = mask_q;
      if (di_i)      mask_d = LVL_NMI;
      else if (ei_i) mask_d = ei_lvl_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_q <= LVL_NMI;
      else        mask_q <= mask_d;
   end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
   import prio_irq_pkg::*;
#(
   parameter int NUM_SRC = 35,
   parameter int SRC_W   = 6
) (
   input  logic [NUM_SRC-1:0] pend_i,
   input  lvl_t [NUM_SRC-1:0] lvl_i,
   input  lvl_t               mask_i,
   output logic               found_o,
   output lvl_t               win_lvl_o,
   output logic [SRC_W-1:0]   win_idx_o
);
   logic [NUM_SRC-1:0] elig;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_elig
      assign elig[i] = pend_i[i] && (lvl_i[i] != LVL_OFF) && (lvl_i[i] >= mask_i);
   end

   always_comb begin
      found_o   = 1'b0;
      win_lvl_o = LVL_OFF;
      win_idx_o = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (elig[i] && lvl_i[i] > win_lvl_o) begin
            found_o   = 1'b1;
            win_lvl_o = lvl_i[i];
            win_idx_o = SRC_W'(i);
         end
      end
   end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
   import prio_irq_pkg::*;
#(
   parameter int          NUM_SRC  = 35,
   parameter int          NMI_IDX  = 0,
   parameter int          VEC_W    = 8,
   parameter logic [7:0]  VEC_BASE = 8'h20,
   localparam int         SRC_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] req_i,
   input  logic               wr_en_i,
   input  logic [SRC_W-1:0]   wr_addr_i,
   input  logic [2:0]         wr_data_i,
   input  logic               ei_i,
   input  logic [2:0]         ei_lvl_i,
   input  logic               di_i,
   input  logic               ack_i,
   output logic               irq_valid_o,
   output logic [2:0]         irq_level_o,
   output logic [VEC_W-1:0]   irq_vec_o
);
   if (NUM_SRC < 2) begin : g_bad_num
      $error("NUM_SRC must be at least 2");
   end
   if (NMI_IDX < 0 || NMI_IDX >= NUM_SRC) begin : g_bad_nmi
      $error("NMI_IDX must select an existing source");
   end
   if (int'(VEC_BASE) + NUM_SRC > (1 << VEC_W)) begin : g_bad_vec
      $error("vector range does not fit VEC_W");
   end

   logic [NUM_SRC-1:0] pend_d;
   lvl_t [NUM_SRC-1:0] lvl_d;
   lvl_t               mask_d, mask_q;
   logic               found;
   lvl_t               win_lvl;
   logic [SRC_W-1:0]   win_idx;
   logic [SRC_W-1:0]   src_q;

   irq_pending #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_pend (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_i    (req_i),
      .clr_en_i (ack_i && irq_valid_o),
      .clr_idx_i(src_q),
      .pend_d   (pend_d)
   );

   irq_level_regs #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W), .NMI_IDX(NMI_IDX)) u_lvl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en_i  (wr_en_i),
      .wr_addr_i(wr_addr_i),
      .wr_data_i(wr_data_i),
      .ei_i     (ei_i),
      .ei_lvl_i (ei_lvl_i),
      .di_i     (di_i),
      .lvl_d    (lvl_d),
      .mask_d   (mask_d),
      .mask_q   (mask_q)
   );

   irq_arbiter #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_arb (
      .pend_i   (pend_d),
      .lvl_i    (lvl_d),
      .mask_i   (mask_d),
      .found_o  (found),
      .win_lvl_o(win_lvl),
      .win_idx_o(win_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_valid_o <= 1'b0;
         irq_level_o <= LVL_OFF;
         irq_vec_o   <= '0;
         src_q       <= '0;
      end else begin
         irq_valid_o <= found;
         irq_level_o <= win_lvl;
         irq_vec_o   <= found ? VEC_W'(VEC_BASE) + VEC_W'(win_idx) : '0;
         src_q       <= win_idx;
      end
   end
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
   parameter int         NUM_SRC  = 35,
   parameter int         NMI_IDX  = 0,
   parameter int         VEC_W    = 8,
   parameter logic [7:0] VEC_BASE = 8'h20
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ack_i,
   input logic             ei_i,
   input logic             di_i,
   input logic             wr_en_i,
   input logic             irq_valid_o,
   input logic [2:0]       irq_level_o,
   input logic [VEC_W-1:0] irq_vec_o,
   input logic [2:0]       mask_q
);
   // R4
   lvl_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid_o |-> irq_level_o != 3'd0);
   // R8
   above_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid_o |-> irq_level_o >= mask_q);
   // R2
   vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid_o |-> (int'(irq_vec_o) >= int'(VEC_BASE)
                       && int'(irq_vec_o) < int'(VEC_BASE) + NUM_SRC));
   // R5
   nmi_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_valid_o && irq_level_o == 3'd7) |-> int'(irq_vec_o) == int'(VEC_BASE) + NMI_IDX);
   // R9
   di_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      di_i |=> (!irq_valid_o || irq_level_o == 3'd7));
   // R10
   hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_valid_o && !ack_i && !ei_i && !di_i && !wr_en_i) |=> irq_valid_o);
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(
   .NUM_SRC(NUM_SRC), .NMI_IDX(NMI_IDX), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ack_i      (ack_i),
   .ei_i       (ei_i),
   .di_i       (di_i),
   .wr_en_i    (wr_en_i),
   .irq_valid_o(irq_valid_o),
   .irq_level_o(irq_level_o),
   .irq_vec_o  (irq_vec_o),
   .mask_q     (mask_q)
);

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int N    = 35;
   localparam int NMI  = 0;
   localparam int BASE = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [N-1:0] req_i = '0;
   logic        wr_en_i = 1'b0;
   logic [5:0]  wr_addr_i = '0;
   logic [2:0]  wr_data_i = '0;
   logic        ei_i = 1'b0;
   logic [2:0]  ei_lvl_i = '0;
   logic        di_i = 1'b0;
   logic        ack_i = 1'b0;
   logic        irq_valid_o;
   logic [2:0]  irq_level_o;
   logic [7:0]  irq_vec_o;

   int checks = 0;
   int failures = 0;
   string phase = "R1";

   prio_irq_ctrl i_prio_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .wr_en_i(wr_en_i),
      .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .ei_i(ei_i),
      .ei_lvl_i(ei_lvl_i), .di_i(di_i), .ack_i(ack_i),
      .irq_valid_o(irq_valid_o), .irq_level_o(irq_level_o), .irq_vec_o(irq_vec_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // behavioural reference model
   int  m_lvl [N];
   bit  m_pend [N];
   int  m_mask;
   bit  e_valid;
   int  e_lvl, e_src;

   task automatic model_pick();
      e_valid = 0; e_lvl = 0; e_src = 0;
      for (int i = 0; i < N; i++) begin
         int l = (i == NMI) ? 7 : m_lvl[i];
         if (m_pend[i] && l != 0 && l >= m_mask && l > e_lvl) begin
            e_valid = 1; e_lvl = l; e_src = i;
         end
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) begin m_lvl[i] = 0; m_pend[i] = 0; end
         m_mask = 7; e_valid = 0; e_lvl = 0; e_src = 0;
      end else begin
         if (ack_i && e_valid) m_pend[e_src] = 0;
         for (int i = 0; i < N; i++) if (req_i[i]) m_pend[i] = 1;
         if (wr_en_i && int'(wr_addr_i) < N && int'(wr_addr_i) != NMI)
            m_lvl[wr_addr_i] = (wr_data_i == 3'd7) ? 6 : int'(wr_data_i);
         if (di_i) m_mask = 7;
         else if (ei_i) m_mask = int'(ei_lvl_i);
         model_pick();
      end
   end

   task automatic check(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         check({phase, " valid"}, int'(irq_valid_o), int'(e_valid));
         if (e_valid) begin
            check({phase, " level"}, int'(irq_level_o), e_lvl);
            check({phase, " vector"}, int'(irq_vec_o), BASE + e_src);
         end
      end
   end

   task automatic expect_out(string tag, bit v, int l, int s);
      check({tag, " directed valid"}, int'(irq_valid_o), int'(v));
      if (v) begin
         check({tag, " directed level"}, int'(irq_level_o), l);
         check({tag, " directed vector"}, int'(irq_vec_o), BASE + s);
      end
   endtask

   task automatic step();
      @(negedge clk);
      req_i = '0; wr_en_i = 0; ei_i = 0; di_i = 0; ack_i = 0;
   endtask
   task automatic pulse(int idx);  req_i[idx] = 1'b1; step(); endtask
   task automatic wr(int a, int d); wr_en_i = 1; wr_addr_i = 6'(a); wr_data_i = 3'(d); step(); endtask
   task automatic ei(int n); ei_i = 1; ei_lvl_i = 3'(n); step(); endtask
   task automatic di(); di_i = 1; step(); endtask
   task automatic ack(); ack_i = 1; step(); endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      step(); step();
      phase = "R1"; expect_out("R1", 0, 0, 0);
      phase = "R4";
      req_i = {{(N-1){1'b1}}, 1'b0}; step();
      expect_out("R4", 0, 0, 0);
      ei(0); expect_out("R4", 0, 0, 0);
      phase = "R5"; pulse(NMI); expect_out("R5", 1, 7, NMI);
      phase = "R10"; ack(); expect_out("R10", 0, 0, 0);
      phase = "R3"; wr(5, 3); expect_out("R3", 1, 3, 5);
      phase = "R7"; wr(9, 3); expect_out("R7", 1, 3, 5);
      phase = "R6"; wr(20, 6); expect_out("R6", 1, 6, 20);
      phase = "R10"; ack(); expect_out("R10", 1, 3, 5);
      phase = "R7"; ack(); expect_out("R7", 1, 3, 9);
      ack(); expect_out("R10", 0, 0, 0);
      phase = "R3"; wr(12, 7); expect_out("R3", 1, 6, 12);
      wr(NMI, 1); expect_out("R3", 1, 6, 12);
      wr(40, 5); expect_out("R3", 1, 6, 12);
      phase = "R8"; di(); expect_out("R8", 0, 0, 0);
      ei_i = 1; ei_lvl_i = 3'd6; di_i = 1; step(); expect_out("R8", 0, 0, 0);
      phase = "R5"; pulse(NMI); expect_out("R5", 1, 7, NMI);
      ack(); expect_out("R5", 0, 0, 0);
      phase = "R9"; ei(6); expect_out("R9", 1, 6, 12);
      ack(); expect_out("R10", 0, 0, 0);
      phase = "R8"; wr(30, 2); expect_out("R8", 0, 0, 0);
      ei(3); expect_out("R8", 0, 0, 0);
      phase = "R9"; ei(2); expect_out("R9", 1, 2, 30);
      phase = "R10"; ack_i = 1; req_i[30] = 1; step(); expect_out("R10", 1, 2, 30);
      ack(); expect_out("R10", 0, 0, 0);
      phase = "R11";
      for (int c = 0; c < 1500; c++) begin
         req_i = N'({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom}
                    & {$urandom, $urandom});
         if ($urandom_range(0, 3) == 0) begin
            wr_en_i = 1; wr_addr_i = 6'($urandom_range(0, 63)); wr_data_i = 3'($urandom);
         end
         if ($urandom_range(0, 15) == 0) begin ei_i = 1; ei_lvl_i = 3'($urandom); end
         if ($urandom_range(0, 31) == 0) di_i = 1;
         ack_i = ($urandom_range(0, 2) == 0);
         step();
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule